// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block keeps the program counter of a single-cycle processor and works out its successor on every rising clock edge. The current PC addresses a small internal instruction store. The 32-bit word found there appears on the output in the same cycle, through a combinational read path. The low 16 bits of that word are the branch displacement.

Control gives the unit a single "this is a branch" flag. The ALU gives it an equality result (Zero). The unit combines the two itself. The PC moves to the branch target only when both are high. In every other case it advances by one word. The branch target is the incremented PC plus the sign-extended displacement scaled by four.

The instruction store is loaded through a write port. That port is accepted only while the unit is held in reset, so a program cannot be changed under a running fetch stream.

Top module: `ifu_fetch`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 at that edge (`pc_o` reads 0 afterwards).
- R2: With `br_sel` low, the next PC is the current PC + 4, whatever the value of `alu_zero`.
- R3: With `br_sel` high and `alu_zero` low, the next PC is the current PC + 4.
- R4: With `br_sel` high and `alu_zero` high, the next PC is PC + 4 + (sign-extended `instr_o[15:0]` × 4).
- R5: `instr_o` always equals the stored word at index `pc_o[9:2]`, in the same cycle the PC takes its value.
- R6: Out of reset, `pc_o[1:0]` is always 00.
- R7: A load with `ld_we` high while `rst` is high writes `ld_data` into word `ld_addr` at the rising edge.
- R8: A load with `ld_we` high while `rst` is low is ignored, and the stored word keeps its old value.
- R9: PCs at or beyond 1024 fetch the word at index `pc_o[9:2]`, which means the store wraps around every 256 words.
- R10: A negative displacement gives a backward target modulo 2^32, and this includes targets below address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also the enable for the load port |
| ld_we | input | 1 | Instruction store write strobe |
| ld_addr | input | 8 | Word index to write |
| ld_data | input | 32 | Word to write |
| br_sel | input | 1 | High when the current instruction is a conditional branch |
| alu_zero | input | 1 | Equality result from the ALU |
| pc_o | output | 32 | Current program counter (byte address) |
| instr_o | output | 32 | Instruction word at the current PC |

## Verification
The bench runs the PC through more than a full lap of the store and checks that the fetch index wraps. A unit that indexed by the wrong PC bits, or that did not wrap, would return the wrong words after address 1020. The bench also drives taken branches whose displacements range from -8 to +7 words, including some from addresses near zero. A unit that zero-extended the displacement, forgot the ×4 scaling, or added it to the old PC instead of PC + 4 would land on the wrong address. Every combination of branch flag and Zero flag is exercised, so a unit that branched on either input alone would move the PC when it should not. Finally, a write is attempted while the unit is running, and the bench reads the target word back through the fetch path to prove the write was dropped.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

   // Source chosen for the next program counter
   typedef enum logic {
      SRC_SEQ = 1'b0,
      SRC_BR  = 1'b1
   } pc_src_e;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned ALIGN_BITS = 2;

endpackage

// File: rtl/ifu_src_sel.sv
module ifu_src_sel
   import ifu_pkg::*;
(
   input  logic    br_sel,
   input  logic    alu_zero,
   output pc_src_e src
);

   // A branch is taken only when control flags a branch and the ALU reports equality
   always_comb begin
      if (br_sel && alu_zero) src = SRC_BR;
      else                    src = SRC_SEQ;
   end

endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
   import ifu_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned IMM_W        = 16,
   parameter bit          PARALLEL_TGT = 1'b1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IMM_W-1:0]  imm,
   input  pc_src_e           src,
   output logic [ADDR_W-1:0] pc_next
);

   localparam int unsigned EXT_W = ADDR_W - IMM_W - ALIGN_BITS;

   logic [ADDR_W-1:0] pc_seq;
   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] pc_tgt;

   // Displacement in bytes: sign-extend, then scale by the word size
   assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_BITS{1'b0}}};
   assign pc_seq = pc + ADDR_W'(WORD_BYTES);

   generate
      if (PARALLEL_TGT) begin : g_par
         // The word step is folded into the offset, so the target add does not wait on the incrementer
         logic [ADDR_W-1:0] off_plus;
         assign off_plus = offset + ADDR_W'(WORD_BYTES);
         assign pc_tgt   = pc + off_plus;
      end else begin : g_ser
         // Chained form: the target add follows the incrementer
         assign pc_tgt = pc_seq + offset;
      end
   endgenerate

   always_comb begin
      unique case (src)
         SRC_BR:  pc_next = pc_tgt;
         default: pc_next = pc_seq;
      endcase
   end

endmodule

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
   parameter int unsigned ADDR_W   = 32,
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q <= ADDR_W'(RESET_PC);
      else     q <= d;
   end

endmodule

// File: rtl/ifu_imem.sv
module ifu_imem #(
   parameter int unsigned WORDS  = 256,
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(WORDS)-1:0] raddr,
   output logic [DATA_W-1:0]        rdata
);

   logic [DATA_W-1:0] mem [WORDS];

   // Writes land at the clock edge
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   // Reads are asynchronous
   assign rdata = mem[raddr];

endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch
   import ifu_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned INSTR_W      = 32,
   parameter int unsigned IMM_W        = 16,
   parameter int unsigned MEM_WORDS    = 256,
   parameter bit          PARALLEL_TGT = 1'b1,
   parameter logic [31:0] RESET_PC     = 32'h0,
   localparam int unsigned IDX_W       = $clog2(MEM_WORDS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ld_we,
   input  logic [IDX_W-1:0]   ld_addr,
   input  logic [INSTR_W-1:0] ld_data,
   input  logic               br_sel,
   input  logic               alu_zero,
   output logic [ADDR_W-1:0]  pc_o,
   output logic [INSTR_W-1:0] instr_o
);

   localparam int unsigned IDX_LO = ALIGN_BITS;
   localparam int unsigned IDX_HI = ALIGN_BITS + IDX_W - 1;

   // Parameter checks at elaboration
   generate
      if ((1 << IDX_W) != MEM_WORDS) begin : g_chk_pow2
         $error("ifu_fetch: MEM_WORDS must be a power of two");
      end
      if (ADDR_W < IMM_W + ALIGN_BITS) begin : g_chk_imm
         $error("ifu_fetch: ADDR_W too narrow for the scaled displacement");
      end
      if (IDX_HI >= ADDR_W) begin : g_chk_idx
         $error("ifu_fetch: instruction store larger than the address space");
      end
      if (INSTR_W < IMM_W) begin : g_chk_iw
         $error("ifu_fetch: instruction narrower than its displacement");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_chk_rst
         $error("ifu_fetch: RESET_PC must be word aligned");
      end
   endgenerate

   pc_src_e            src;
   logic [ADDR_W-1:0]  pc_next;
   logic               mem_we;

   // The store may only change while fetch is held in reset
   assign mem_we = ld_we & rst;

   ifu_src_sel u_sel (
      .br_sel   (br_sel),
      .alu_zero (alu_zero),
      .src      (src)
   );

   ifu_next_pc #(
      .ADDR_W       (ADDR_W),
      .IMM_W        (IMM_W),
      .PARALLEL_TGT (PARALLEL_TGT)
   ) u_npc (
      .pc      (pc_o),
      .imm     (instr_o[IMM_W-1:0]),
      .src     (src),
      .pc_next (pc_next)
   );

   ifu_pc_reg #(
      .ADDR_W   (ADDR_W),
      .RESET_PC (RESET_PC)
   ) u_pc (
      .clk (clk),
      .rst (rst),
      .d   (pc_next),
      .q   (pc_o)
   );

   ifu_imem #(
      .WORDS  (MEM_WORDS),
      .DATA_W (INSTR_W)
   ) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (pc_o[IDX_HI:IDX_LO]),
      .rdata (instr_o)
   );

endmodule

// File: rtl/ifu_chk.sv
module ifu_chk #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned IMM_W   = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               br_sel,
   input logic               alu_zero,
   input logic [ADDR_W-1:0]  pc_o,
   input logic [INSTR_W-1:0] instr_o
);

   logic [ADDR_W-1:0] disp;
   assign disp = ADDR_W'($signed(instr_o[IMM_W-1:0])) << 2;

   // R1
   p_reset_zero_r1: assert property (@(posedge clk)
      rst |=> (pc_o == '0));

   // R2
   p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
      !br_sel |=> (pc_o == $past(pc_o) + ADDR_W'(4)));

   // R3
   p_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
      (br_sel && !alu_zero) |=> (pc_o == $past(pc_o) + ADDR_W'(4)));

   // R4, R10
   p_taken_r4: assert property (@(posedge clk) disable iff (rst)
      (br_sel && alu_zero) |=> (pc_o == $past(pc_o) + ADDR_W'(4) + $past(disp)));

   // R6
   p_aligned_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (pc_o[1:0] == 2'b00));

endmodule

bind ifu_fetch ifu_chk #(
   .ADDR_W  (ADDR_W),
   .INSTR_W (INSTR_W),
   .IMM_W   (IMM_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .br_sel   (br_sel),
   .alu_zero (alu_zero),
   .pc_o     (pc_o),
   .instr_o  (instr_o)
);

// File: tb/ifu_fetch_tb.sv
module ifu_fetch_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ld_we = 1'b0;
   logic [7:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic        br_sel = 1'b0;
   logic        alu_zero = 1'b0;
   logic [31:0] pc_o;
   logic [31:0] instr_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [31:0] model [256];
   logic [31:0] exp_pc;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;   // 50 MHz

   ifu_fetch dut_i (
      .clk      (clk),
      .rst      (rst),
      .ld_we    (ld_we),
      .ld_addr  (ld_addr),
      .ld_data  (ld_data),
      .br_sel   (br_sel),
      .alu_zero (alu_zero),
      .pc_o     (pc_o),
      .instr_o  (instr_o)
   );

   function automatic logic [31:0] pattern(int i);
      logic [7:0] b;
      b = 8'(i);
      // displacement = (i mod 16) - 8 words
      return {b, ~b, {13{~b[3]}}, b[2:0]};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Check outputs at the current negedge, then apply one branch/zero pair
   task automatic step(logic b, logic z);
      logic [31:0] soff;
      logic [15:0] imm;
      check(exp_pc[31:10] != 0 ? "R9" : "R5", instr_o, model[exp_pc[9:2]]);
      check("R6", {30'd0, pc_o[1:0]}, 32'd0);
      imm  = model[exp_pc[9:2]][15:0];
      soff = {{14{imm[15]}}, imm, 2'b00};
      br_sel   = b;
      alu_zero = z;
      exp_pc   = exp_pc + 32'd4 + ((b && z) ? soff : 32'd0);
      @(negedge clk);
      if (b && z) check(imm[15] ? "R10" : "R4", pc_o, exp_pc);
      else if (b) check("R3", pc_o, exp_pc);
      else        check("R2", pc_o, exp_pc);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog R5 run did not finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // Load the store while in reset (R7)
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         ld_we   = 1'b1;
         ld_addr = 8'(i);
         ld_data = pattern(i);
         model[i] = pattern(i);
      end
      @(negedge clk);
      ld_we = 1'b0;
      @(negedge clk);
      check("R1", pc_o, 32'd0);
      check("R7", instr_o, model[0]);

      rst    = 1'b0;
      exp_pc = 32'd0;

      // Sequential lap and beyond, Zero toggling (R2, R5, R9)
      for (int k = 0; k < 300; k++) step(1'b0, k[0]);
      // Branch flagged, not equal (R3)
      for (int k = 0; k < 100; k++) step(1'b1, 1'b0);
      // Taken branches, forward and backward (R4, R10)
      for (int k = 0; k < 200; k++) step(1'b1, 1'b1);
      // Mixed pseudo-random pattern
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[0], lfsr[1]);
      end

      // Reset mid-run with a taken branch pending (R1)
      rst = 1'b1; br_sel = 1'b1; alu_zero = 1'b1;
      @(negedge clk);
      check("R1", pc_o, 32'd0);
      br_sel = 1'b0; alu_zero = 1'b0;
      ld_we = 1'b1; ld_addr = 8'd0; ld_data = 32'hC0DE_0004;
      @(negedge clk);
      ld_we = 1'b0;
      model[0] = 32'hC0DE_0004;
      check("R7", instr_o, 32'hC0DE_0004);

      // Running: write attempt must be dropped (R8)
      rst = 1'b0;
      ld_we = 1'b1; ld_addr = 8'd1; ld_data = 32'hDEAD_BEEF;
      @(negedge clk);
      ld_we = 1'b0;
      check("R2", pc_o, 32'd4);
      check("R8", instr_o, model[1]);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule